// File: doc/BRIEF.md
# Cascadable Presettable Synchronous Binary Counter

This block is a synchronous up-counter built from identical 4-bit stages. Every stage is clocked by the same rising edge, so all count bits settle together. Each stage has the following controls:

- an active-low synchronous clear;
- an active-low synchronous parallel load;
- two count enables with different roles.

The first enable, `enCount`, is shared by all stages. The second enable, `enChain`, is passed from stage to stage through each stage's carry output. Because of this, the chained stages behave as one wide binary counter, and no extra gating is needed between them.

A typical use is a wide event or timer counter. Software-free preset comes from the parallel load. A shorter count length is obtained by decoding a chosen count value outside the block into an active-low signal on `clearN`. The per-stage carry outputs and the final carry can enable further counters downstream.

Top module: `cascade_counter`

## Requirements
- R1: The count changes only at a rising clock edge. Toggling `loadN`, `enCount` or `enChain` between edges and restoring them before the edge leaves the count unchanged.
- R2: When `clearN` is low at a rising edge, the whole count becomes zero. This holds for any level of `loadN`, `enCount` and `enChain`, so clear has priority over load.
- R3: When `clearN` is high and `loadN` is low at a rising edge, the count takes the value of `loadData`. The enable levels do not matter. Stage k loads bits [4k+3:4k].
- R4: When `clearN`, `loadN`, `enCount` and `enChain` are all high at a rising edge, the count rises by one as a single binary number of 4·STAGES bits. It wraps from all ones to zero.
- R5: With `clearN` and `loadN` high, the count holds its value if either `enCount` or `enChain` is low.
- R6: `stageCarry[k]` is high exactly when `enChain` is high and the nibbles of stages 0 through k are all ones (value 15). `carryOut` equals `stageCarry[STAGES-1]`.
- R7: The carry outputs follow `enChain` combinationally within the same clock cycle, with no clock edge needed.
- R8: Driving `clearN` low while the count equals K returns the count to zero on the next edge. Counting then repeats with a period of K+1 edges.
- R9: With both enables held high, `stageCarry[0]` is high for exactly one edge out of every 16 counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock shared by all stages |
| clearN | input | 1 | Synchronous clear, active low, highest priority |
| loadN | input | 1 | Synchronous parallel load, active low |
| enCount | input | 1 | Count enable shared by every stage |
| enChain | input | 1 | Count enable for the first stage; also gates the carry chain |
| loadData | input | 4*STAGES | Preset value |
| count | output | 4*STAGES | Current count, stage 0 in the low nibble |
| stageCarry | output | STAGES | Carry output of each stage |
| carryOut | output | 1 | Carry output of the last stage |

## Verification
A wrong stored nibble shows on `count` right after the edge that stores it. It also corrupts the carry outputs in the same cycle, and the carry outputs in turn change how the higher stages increment on the next edge. A faulty enable or carry link shows up first at a nibble boundary, such as the step from 0x0FF to 0x100, so the stimulus walks across those boundaries. A priority error between clear, load and count is visible one edge after the conflicting controls are applied. A reference model compares the full count every cycle.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  localparam int NIBBLE = 4;

  typedef struct packed {
    logic doClear;
    logic doLoad;
    logic doInc;
  } ctrStrobe_t;
endpackage

// File: rtl/ctr_ctrl.sv
module ctr_ctrl
  import cnt_pkg::*;
(
  input  logic       clearN,
  input  logic       loadN,
  input  logic       enP,
  input  logic       enT,
  output ctrStrobe_t strobe
);
  // Priority order: clear, then load, then count.
  always_comb begin
    strobe = '0;
    if (!clearN)         strobe.doClear = 1'b1;
    else if (!loadN)     strobe.doLoad  = 1'b1;
    else if (enP && enT) strobe.doInc   = 1'b1;
  end
endmodule

// File: rtl/ctr_datapath.sv
module ctr_datapath
  import cnt_pkg::*;
#(
  parameter int WIDTH = NIBBLE
) (
  input  logic             clk,
  input  ctrStrobe_t       strobe,
  input  logic [WIDTH-1:0] data,
  output logic [WIDTH-1:0] q,
  output logic             atMax
);
  localparam logic [WIDTH-1:0] ALL_ONES = '1;
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] qNext;

  always_comb begin
    qNext = q;
    if (strobe.doClear)     qNext = '0;
    else if (strobe.doLoad) qNext = data;
    else if (strobe.doInc)  qNext = q + ONE;
  end

  always_ff @(posedge clk) q <= qNext;

  assign atMax = (q == ALL_ONES);
endmodule

// File: rtl/ctr_stage.sv
module ctr_stage
  import cnt_pkg::*;
(
  input  logic              clk,
  input  logic              clearN,
  input  logic              loadN,
  input  logic              enP,
  input  logic              enT,
  input  logic [NIBBLE-1:0] data,
  output logic [NIBBLE-1:0] q,
  output logic              rco
);
  ctrStrobe_t strobe;
  logic       atMax;

  ctr_ctrl ctrl_i (
    .clearN(clearN), .loadN(loadN), .enP(enP), .enT(enT), .strobe(strobe)
  );

  ctr_datapath #(.WIDTH(NIBBLE)) dp_i (
    .clk(clk), .strobe(strobe), .data(data), .q(q), .atMax(atMax)
  );

  // Carry is gated by enT directly so it can feed the next stage's enT.
  assign rco = enT & atMax;
endmodule

// File: rtl/cascade_counter.sv
module cascade_counter
  import cnt_pkg::*;
#(
  parameter int STAGES = 3,
  localparam int WIDTH = STAGES * NIBBLE
) (
  input  logic              clk,
  input  logic              clearN,
  input  logic              loadN,
  input  logic              enCount,
  input  logic              enChain,
  input  logic [WIDTH-1:0]  loadData,
  output logic [WIDTH-1:0]  count,
  output logic [STAGES-1:0] stageCarry,
  output logic              carryOut
);
  logic [STAGES:0] chainEn;
  assign chainEn[0] = enChain;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    ctr_stage stage_i (
      .clk   (clk),
      .clearN(clearN),
      .loadN (loadN),
      .enP   (enCount),
      .enT   (chainEn[k]),
      .data  (loadData[k*NIBBLE +: NIBBLE]),
      .q     (count[k*NIBBLE +: NIBBLE]),
      .rco   (stageCarry[k])
    );
    assign chainEn[k+1] = stageCarry[k];
  end

  assign carryOut = stageCarry[STAGES-1];
endmodule

// File: rtl/cascade_counter_chk.sv
module cascade_counter_chk
  import cnt_pkg::*;
#(
  parameter int STAGES = 3,
  localparam int WIDTH = STAGES * NIBBLE
) (
  input logic              clk,
  input logic              clearN,
  input logic              loadN,
  input logic              enCount,
  input logic              enChain,
  input logic [WIDTH-1:0]  loadData,
  input logic [WIDTH-1:0]  count,
  input logic [STAGES-1:0] stageCarry,
  input logic              carryOut
);
  localparam logic [WIDTH-1:0] ALL_ONES = '1;
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  // Armed one edge after the first clear, once the count is defined.
  logic armed = 1'b0;
  always_ff @(posedge clk) if (!clearN) armed <= 1'b1;

  a_r2_clear: assert property (@(posedge clk) disable iff (!armed)
    !clearN |=> count == '0);

  a_r3_load: assert property (@(posedge clk) disable iff (!armed)
    (clearN && !loadN) |=> count == $past(loadData));

  a_r4_increment: assert property (@(posedge clk) disable iff (!armed)
    (clearN && loadN && enCount && enChain) |=> count == $past(count) + ONE);

  a_r5_hold: assert property (@(posedge clk) disable iff (!armed)
    (clearN && loadN && !(enCount && enChain)) |=> $stable(count));

  a_r6_last_carry: assert property (@(posedge clk) disable iff (!armed)
    carryOut |-> (enChain && count == ALL_ONES));

  a_r6_first_carry: assert property (@(posedge clk) disable iff (!armed)
    stageCarry[0] |-> (enChain && count[NIBBLE-1:0] == '1));

  a_r6_carry_order: assert property (@(posedge clk) disable iff (!armed)
    carryOut |-> $countones(stageCarry) == STAGES);
endmodule

bind cascade_counter cascade_counter_chk #(.STAGES(STAGES)) chk_i (.*);

// File: tb/cascade_counter_tb_top.sv
module cascade_counter_tb_top;
  localparam int STAGES = 3;
  localparam int W = 12;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          clearN = 1'b1, loadN = 1'b1, enCount = 1'b0, enChain = 1'b0;
  logic [W-1:0]  loadData = '0;
  logic [W-1:0]  count;
  logic [STAGES-1:0] stageCarry;
  logic          carryOut;

  cascade_counter #(.STAGES(STAGES)) dut_i (
    .clk(clk), .clearN(clearN), .loadN(loadN), .enCount(enCount),
    .enChain(enChain), .loadData(loadData), .count(count),
    .stageCarry(stageCarry), .carryOut(carryOut)
  );

  int nChecks = 0, nFails = 0;
  logic [W-1:0] model;

  // Vector: {clearN, loadN, enCount, enChain, data[11:0], expected[11:0]}
  localparam int NV = 12;
  localparam logic [27:0] VEC [NV] = '{
    {4'b0111, 12'h000, 12'h000},  // R2 clear
    {4'b1011, 12'h0FE, 12'h0FE},  // R3 load ignores enables
    {4'b1111, 12'h000, 12'h0FF},  // R4 count
    {4'b1111, 12'h000, 12'h100},  // R4 nibble boundary
    {4'b1101, 12'h000, 12'h100},  // R5 enCount low
    {4'b1110, 12'h000, 12'h100},  // R5 enChain low
    {4'b0011, 12'hFFF, 12'h000},  // R2 clear over load
    {4'b1000, 12'hFFF, 12'hFFF},  // R3 load, enables low
    {4'b1111, 12'h000, 12'h000},  // R4 wrap
    {4'b1011, 12'h5A5, 12'h5A5},  // R3 load over count
    {4'b1111, 12'h000, 12'h5A6},  // R4 count
    {4'b0111, 12'h000, 12'h000}   // R2 clear over count
  };

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Advance to just after the next rising edge.
  task automatic step();
    @(posedge clk); #1;
  endtask

  function automatic logic [STAGES-1:0] carryModel(input logic [W-1:0] c, input logic t);
    logic [STAGES-1:0] r;
    logic run = t;
    for (int k = 0; k < STAGES; k++) begin
      run = run & (c[k*4 +: 4] == 4'hF);
      r[k] = run;
    end
    return r;
  endfunction

  initial begin
    #1;
    // Vector table
    for (int i = 0; i < NV; i++) begin
      {clearN, loadN, enCount, enChain} = VEC[i][27:24];
      loadData = VEC[i][23:12];
      step();
      check($sformatf("R2/R3/R4/R5 vec%0d", i), count, VEC[i][11:0]);
    end

    // R6, R7: carry follows enChain combinationally at all ones
    clearN = 1; loadN = 0; loadData = 12'hFFF; enCount = 0; enChain = 0;
    step();
    loadN = 1; #2;
    check("R7 carry low with enChain low", {9'd0, stageCarry}, 12'h000);
    enChain = 1; #1;
    check("R7 carry follows enChain", {9'd0, stageCarry}, 12'h007);
    check("R6 carryOut", {11'd0, carryOut}, 12'h001);
    check("R7 count unchanged", count, 12'hFFF);
    enChain = 0;

    // R1: glitch controls between edges
    loadData = 12'h123; loadN = 0; enCount = 1; enChain = 1; #1;
    loadN = 1; enCount = 0; enChain = 0;
    step();
    check("R1 mid-cycle toggles ignored", count, 12'hFFF);

    // R9: one carry per 16 counts of stage 0
    clearN = 0; step(); clearN = 1; enCount = 1; enChain = 1;
    begin
      int pulses = 0;
      for (int i = 0; i < 64; i++) begin
        #2; if (stageCarry[0]) pulses++;
        step();
      end
      check("R9 carry pulses per 64 counts", 12'(pulses), 12'd4);
    end
    check("R4 after 64 counts", count, 12'h040);

    // R8: decode 9 into clear, period 10
    clearN = 0; step(); clearN = 1;
    begin
      logic ok = 1;
      for (int i = 1; i <= 25; i++) begin
        clearN = !(count == 12'd9);
        step();
        if (count !== 12'(i % 10)) ok = 0;
      end
      check("R8 modulo-10 sequence", {11'd0, ok}, 12'h001);
    end
    clearN = 1;

    // Random sequence against the reference model (R2 R3 R4 R5 R6)
    clearN = 0; step(); model = '0;
    for (int i = 0; i < 400; i++) begin
      int r = $urandom_range(0, 15);
      clearN = (r != 0);
      loadN = (r > 1);
      enCount = ($urandom_range(0, 7) != 0);
      enChain = ($urandom_range(0, 7) != 0);
      loadData = (r == 2) ? 12'hFFD : 12'($urandom);
      #1;
      check("R6 random carry", {9'd0, stageCarry}, {9'd0, carryModel(model, enChain)});
      if (!clearN) model = '0;
      else if (!loadN) model = loadData;
      else if (enCount && enChain) model = model + 12'd1;
      step();
      check("R2/R3/R4/R5 random", count, model);
    end

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #1000000;
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule